// File: doc/BRIEF.md
# Prefixed Opcode Decoder with Index Substitution

This block sits at the front of an 8-bit CPU's instruction path. It receives opcode fetch bytes one at a time. It tracks the prefix bytes CB, DD, ED and FD and works out what the finished instruction means. A prefix changes how the byte after it is read. DD and FD make the instruction use an index register (X or Y) where it would otherwise use the HL pair. CB selects the bit-operation page. ED selects the extended page. DD CB or FD CB selects the indexed bit-operation page.

When a non-prefix byte completes an instruction, the decoder gives a one-cycle `decodeValid` pulse. With it come:
- the page;
- the index register in use;
- whether a signed displacement byte belongs to the instruction;
- remapped 4-bit source and destination register selects;
- a special-behaviour code;
- the number of fetch cycles, which the refresh counter uses.

A prefix that a later DD, FD or ED makes void is reported as its own 4-T-state no-operation, through `prefixDrop`. Undefined extended opcodes are reported as 8-T-state no-operations. In the indexed bit-operation form, the decoder consumes the displacement byte between the CB and the final opcode itself.

Top module: `prefix_decoder`

## Requirements
- R1: `decodeValid` rises in the cycle after the completing byte is accepted (`byteValid` high). `page` is 0 for main, 1 for CB, 2 for ED and 3 for DD CB / FD CB. `refreshInc` is 1 for an unprefixed main opcode and 2 for every other completed instruction. Register select codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory through HL, 7 A, 8 X-high, 9 X-low, 10 Y-high, 11 Y-low, 12 memory through X plus displacement, 13 memory through Y plus displacement, and 15 none. Main page: opcodes 40–7F except 76 give dst=bits 5:3 and src=bits 2:0. Opcodes 80–BF give dst=7 and src=bits 2:0. In 00–3F, low field 4 or 5 gives src=dst=bits 5:3, and low field 6 gives dst=bits 5:3. Every other main opcode gives 15/15.
- R2: After DD, `idxSel` is 1 (X). After FD, it is 2 (Y). Without an index prefix it is 0. Pages 1 and 2 always report 0. In an indexed main-page instruction, a memory operand (code 6) becomes 12 for X or 13 for Y, and `needDisp` is 1.
- R3: In an indexed main-page instruction with no memory operand, H becomes 8 or 10 and L becomes 9 or 11, for X or Y respectively.
- R4: In an indexed main-page instruction that has a memory operand, an H or L in the other operand stays 4 or 5.
- R5: In an indexed main-page instruction that names none of H, L or memory, the selects are unchanged and `needDisp` is 0.
- R6: A DD or FD that follows a pending DD or FD, and an ED that follows a pending DD or FD, each raise `prefixDrop` in the next cycle. With it, `tStates`=4, `refreshInc`=1 and `decodeValid`=0. The last index prefix alone chooses `idxSel`. After ED, `idxSel` is 0.
- R7: Opcodes 30–37 on page 1 or page 3 report `kind`=1 (left shift that sets bit 0). Other codes there report `kind`=0. Page 1 gives src=dst=bits 2:0.
- R8: On page 2, these opcodes report `kind`=5, `tStates`=8 and selects 15/15: 00–3F, 77, 7F, and 80–FF except the block opcodes A0–A3, A8–AB, B0–B3 and B8–BB. Any other completion has `tStates`=0. On page 2, opcodes 40–7F with low field 0 give dst=bits 5:3, and those with low field 1 give src=bits 5:3. In both cases a field of 6 gives 15 instead.
- R9: Extended opcode 70 reports `kind`=2 (port read that keeps only the flags). Extended opcode 71 reports `kind`=3 (port write of zero).
- R10: Main opcode E9 reports `kind`=4 (register jump), with or without an index prefix. `needDisp` is 0.
- R11: For DD CB or FD CB, the next byte is taken as the displacement and produces no output. The byte after it completes the instruction with page 3, src=dst=12 or 13, and `needDisp`=1.
- R12: After reset, and in every cycle without a pulse, outputs are 0 except src=dst=15. The prefix state clears with each completion, so the next byte decodes unprefixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | An opcode fetch byte is present this cycle |
| opByte | input | 8 | Opcode fetch byte |
| decodeValid | output | 1 | Pulse: an instruction was completed |
| prefixDrop | output | 1 | Pulse: a superseded prefix retired as a no-operation |
| page | output | 2 | Opcode page |
| idxSel | output | 2 | Index register replacing HL (0 none, 1 X, 2 Y) |
| needDisp | output | 1 | A displacement byte belongs to the instruction |
| srcSel | output | 4 | Remapped source register select |
| dstSel | output | 4 | Remapped destination register select |
| kind | output | 3 | Special behaviour code |
| refreshInc | output | 2 | Fetch cycles to add to the refresh counter |
| tStates | output | 4 | T-state count for prefix-only and undefined cases |

## Verification
A wrong prefix state shows at the port on the next completing byte. It appears as a wrong `page`, a wrong `idxSel`, or a stray or missing `prefixDrop`, one cycle after that byte. A lost or stale index register shows up as H/L selects mapped to the wrong half, or as a memory code of 12 where 13 was due. The bench's reference model compares every output in every cycle, so it detects a fault within one cycle of the byte that exposes it. A state that fails to clear after a completion shows on the very next opcode, which then decodes as prefixed.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  typedef enum logic [1:0] {PG_MAIN, PG_BIT, PG_EXT, PG_IXBIT} page_t;
  typedef enum logic [1:0] {IX_NONE, IX_X, IX_Y} idx_t;
  typedef enum logic [2:0] {
    K_NORMAL, K_SHIFT_SET, K_PORT_PEEK, K_PORT_ZERO, K_REG_JUMP, K_EXT_NOP
  } kind_t;

  typedef struct packed {
    logic  finish;
    logic  drop;
    page_t page;
    idx_t  idx;
    logic  twoFetch;
  } strobe_t;

  localparam logic [7:0] BYTE_BIT = 8'hCB;
  localparam logic [7:0] BYTE_EXT = 8'hED;
  localparam logic [7:0] BYTE_IX  = 8'hDD;
  localparam logic [7:0] BYTE_IY  = 8'hFD;

  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_H     = 4'd4;
  localparam logic [SEL_W-1:0] SEL_L     = 4'd5;
  localparam logic [SEL_W-1:0] SEL_MEM   = 4'd6;
  localparam logic [SEL_W-1:0] SEL_A     = 4'd7;
  localparam logic [SEL_W-1:0] SEL_XH    = 4'd8;
  localparam logic [SEL_W-1:0] SEL_XL    = 4'd9;
  localparam logic [SEL_W-1:0] SEL_YH    = 4'd10;
  localparam logic [SEL_W-1:0] SEL_YL    = 4'd11;
  localparam logic [SEL_W-1:0] SEL_XMEM  = 4'd12;
  localparam logic [SEL_W-1:0] SEL_YMEM  = 4'd13;
  localparam logic [SEL_W-1:0] SEL_NONE  = 4'd15;

endpackage

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
  import pdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] opByte,
  output strobe_t    strobe
);

  typedef enum logic [2:0] {S_IDLE, S_IDX, S_BIT, S_EXT, S_IXDISP, S_IXOP} state_t;

  state_t stateQ, stateD;
  idx_t   idxQ, idxD;

  logic isIdx, isBit, isExt;
  idx_t byteIdx;

  assign isIdx   = (opByte == BYTE_IX) || (opByte == BYTE_IY);
  assign isBit   = (opByte == BYTE_BIT);
  assign isExt   = (opByte == BYTE_EXT);
  assign byteIdx = (opByte == BYTE_IX) ? IX_X : IX_Y;

  always_comb begin
    stateD          = stateQ;
    idxD            = idxQ;
    strobe.finish   = 1'b0;
    strobe.drop     = 1'b0;
    strobe.page     = PG_MAIN;
    strobe.idx      = IX_NONE;
    strobe.twoFetch = 1'b0;
    if (byteValid) begin
      unique case (stateQ)
        S_IDLE: begin
          if (isBit) stateD = S_BIT;
          else if (isExt) stateD = S_EXT;
          else if (isIdx) begin
            stateD = S_IDX;
            idxD   = byteIdx;
          end else begin
            strobe.finish = 1'b1;
          end
        end
        S_IDX: begin
          if (isIdx) begin
            strobe.drop = 1'b1;
            idxD        = byteIdx;
          end else if (isExt) begin
            strobe.drop = 1'b1;
            idxD        = IX_NONE;
            stateD      = S_EXT;
          end else if (isBit) begin
            stateD = S_IXDISP;
          end else begin
            strobe.finish   = 1'b1;
            strobe.idx      = idxQ;
            strobe.twoFetch = 1'b1;
            stateD          = S_IDLE;
            idxD            = IX_NONE;
          end
        end
        S_BIT: begin
          strobe.finish   = 1'b1;
          strobe.page     = PG_BIT;
          strobe.twoFetch = 1'b1;
          stateD          = S_IDLE;
        end
        S_EXT: begin
          strobe.finish   = 1'b1;
          strobe.page     = PG_EXT;
          strobe.twoFetch = 1'b1;
          stateD          = S_IDLE;
        end
        S_IXDISP: stateD = S_IXOP;
        S_IXOP: begin
          strobe.finish   = 1'b1;
          strobe.page     = PG_IXBIT;
          strobe.idx      = idxQ;
          strobe.twoFetch = 1'b1;
          stateD          = S_IDLE;
          idxD            = IX_NONE;
        end
        default: stateD = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      idxQ   <= IX_NONE;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

endmodule

// File: rtl/pdec_datapath.sv
module pdec_datapath
  import pdec_pkg::*;
#(
  parameter int PREFIX_NOP_T = 4,
  parameter int EXT_NOP_T    = 8,
  localparam int T_MAX = (PREFIX_NOP_T > EXT_NOP_T) ? PREFIX_NOP_T : EXT_NOP_T,
  localparam int T_W   = $clog2(T_MAX + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       opByte,
  input  strobe_t          strobe,
  output logic             decodeValid,
  output logic             prefixDrop,
  output logic [1:0]       page,
  output logic [1:0]       idxSel,
  output logic             needDisp,
  output logic [SEL_W-1:0] srcSel,
  output logic [SEL_W-1:0] dstSel,
  output logic [2:0]       kind,
  output logic [1:0]       refreshInc,
  output logic [T_W-1:0]   tStates
);

  logic [2:0]       fldY, fldZ;
  logic [SEL_W-1:0] rawSel [2];
  logic [SEL_W-1:0] mapSel [2];
  kind_t            kindC;
  logic             isBlock, extNop, memUse, rawMem;

  assign fldY    = opByte[5:3];
  assign fldZ    = opByte[2:0];
  assign isBlock = (opByte[7:5] == 3'b101) && !opByte[2];
  assign extNop  = (opByte[7:6] == 2'b00) || (opByte[7] && !isBlock) ||
                   (opByte == 8'h77) || (opByte == 8'h7F);

  always_comb begin
    rawSel[0] = SEL_NONE;
    rawSel[1] = SEL_NONE;
    kindC     = K_NORMAL;
    unique case (strobe.page)
      PG_MAIN: begin
        if (opByte[7:6] == 2'b01 && opByte != 8'h76) begin
          rawSel[1] = {1'b0, fldY};
          rawSel[0] = {1'b0, fldZ};
        end else if (opByte[7:6] == 2'b10) begin
          rawSel[1] = SEL_A;
          rawSel[0] = {1'b0, fldZ};
        end else if (opByte[7:6] == 2'b00) begin
          if (fldZ == 3'd4 || fldZ == 3'd5) begin
            rawSel[1] = {1'b0, fldY};
            rawSel[0] = {1'b0, fldY};
          end else if (fldZ == 3'd6) begin
            rawSel[1] = {1'b0, fldY};
          end
        end
        if (opByte == 8'hE9) kindC = K_REG_JUMP;
      end
      PG_BIT: begin
        rawSel[1] = {1'b0, fldZ};
        rawSel[0] = {1'b0, fldZ};
        if (opByte[7:3] == 5'b00110) kindC = K_SHIFT_SET;
      end
      PG_EXT: begin
        if (opByte[7:6] == 2'b01 && fldY != 3'd6) begin
          if (fldZ == 3'd0) rawSel[1] = {1'b0, fldY};
          if (fldZ == 3'd1) rawSel[0] = {1'b0, fldY};
        end
        if (opByte == 8'h70) kindC = K_PORT_PEEK;
        else if (opByte == 8'h71) kindC = K_PORT_ZERO;
        else if (extNop) kindC = K_EXT_NOP;
      end
      PG_IXBIT: begin
        rawSel[1] = SEL_MEM;
        rawSel[0] = SEL_MEM;
        if (opByte[7:3] == 5'b00110) kindC = K_SHIFT_SET;
      end
      default: ;
    endcase
  end

  assign rawMem = (rawSel[0] == SEL_MEM) || (rawSel[1] == SEL_MEM);
  assign memUse = (strobe.idx != IX_NONE) && rawMem &&
                  (strobe.page == PG_MAIN || strobe.page == PG_IXBIT);

  function automatic logic [SEL_W-1:0] remapSel(input logic [SEL_W-1:0] code,
                                                input idx_t ix, input logic mem);
    logic [SEL_W-1:0] r;
    r = code;
    if (ix != IX_NONE) begin
      if (mem) begin
        if (code == SEL_MEM) r = (ix == IX_X) ? SEL_XMEM : SEL_YMEM;
      end else begin
        if (code == SEL_H) r = (ix == IX_X) ? SEL_XH : SEL_YH;
        if (code == SEL_L) r = (ix == IX_X) ? SEL_XL : SEL_YL;
      end
    end
    return r;
  endfunction

  idx_t effIdx;
  assign effIdx = (strobe.page == PG_MAIN || strobe.page == PG_IXBIT) ? strobe.idx : IX_NONE;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    assign mapSel[g] = remapSel(rawSel[g], effIdx, memUse);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decodeValid <= 1'b0;
      prefixDrop  <= 1'b0;
      page        <= 2'd0;
      idxSel      <= 2'd0;
      needDisp    <= 1'b0;
      srcSel      <= SEL_NONE;
      dstSel      <= SEL_NONE;
      kind        <= 3'd0;
      refreshInc  <= 2'd0;
      tStates     <= '0;
    end else begin
      decodeValid <= strobe.finish;
      prefixDrop  <= strobe.drop;
      page        <= 2'd0;
      idxSel      <= 2'd0;
      needDisp    <= 1'b0;
      srcSel      <= SEL_NONE;
      dstSel      <= SEL_NONE;
      kind        <= 3'd0;
      refreshInc  <= 2'd0;
      tStates     <= '0;
      if (strobe.finish) begin
        page       <= strobe.page;
        idxSel     <= effIdx;
        needDisp   <= memUse;
        srcSel     <= mapSel[0];
        dstSel     <= mapSel[1];
        kind       <= kindC;
        refreshInc <= strobe.twoFetch ? 2'd2 : 2'd1;
        tStates    <= (kindC == K_EXT_NOP) ? T_W'(EXT_NOP_T) : '0;
      end else if (strobe.drop) begin
        refreshInc <= 2'd1;
        tStates    <= T_W'(PREFIX_NOP_T);
      end
    end
  end

endmodule

// File: rtl/prefix_decoder.sv
module prefix_decoder
  import pdec_pkg::*;
#(
  parameter int PREFIX_NOP_T = 4,
  parameter int EXT_NOP_T    = 8,
  localparam int T_MAX = (PREFIX_NOP_T > EXT_NOP_T) ? PREFIX_NOP_T : EXT_NOP_T,
  localparam int T_W   = $clog2(T_MAX + 1)
)(
  input  logic           clk,
  input  logic           rstN,
  input  logic           byteValid,
  input  logic [7:0]     opByte,
  output logic           decodeValid,
  output logic           prefixDrop,
  output logic [1:0]     page,
  output logic [1:0]     idxSel,
  output logic           needDisp,
  output logic [3:0]     srcSel,
  output logic [3:0]     dstSel,
  output logic [2:0]     kind,
  output logic [1:0]     refreshInc,
  output logic [T_W-1:0] tStates
);

  strobe_t strobe;

  pdec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .opByte    (opByte),
    .strobe    (strobe)
  );

  pdec_datapath #(
    .PREFIX_NOP_T (PREFIX_NOP_T),
    .EXT_NOP_T    (EXT_NOP_T)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .opByte      (opByte),
    .strobe      (strobe),
    .decodeValid (decodeValid),
    .prefixDrop  (prefixDrop),
    .page        (page),
    .idxSel      (idxSel),
    .needDisp    (needDisp),
    .srcSel      (srcSel),
    .dstSel      (dstSel),
    .kind        (kind),
    .refreshInc  (refreshInc),
    .tStates     (tStates)
  );

endmodule

// File: rtl/prefix_decoder_checker.sv
module prefix_decoder_checker #(
  parameter int PREFIX_NOP_T = 4,
  parameter int EXT_NOP_T    = 8,
  localparam int T_MAX = (PREFIX_NOP_T > EXT_NOP_T) ? PREFIX_NOP_T : EXT_NOP_T,
  localparam int T_W   = $clog2(T_MAX + 1)
)(
  input logic           clk,
  input logic           rstN,
  input logic           byteValid,
  input logic [7:0]     opByte,
  input logic           decodeValid,
  input logic           prefixDrop,
  input logic [1:0]     page,
  input logic [1:0]     idxSel,
  input logic           needDisp,
  input logic [3:0]     srcSel,
  input logic [3:0]     dstSel,
  input logic [2:0]     kind,
  input logic [1:0]     refreshInc,
  input logic [T_W-1:0] tStates
);

  logic srcHalf, dstHalf, srcIxMem, dstIxMem;
  assign srcHalf  = (srcSel >= 4'd8) && (srcSel <= 4'd11);
  assign dstHalf  = (dstSel >= 4'd8) && (dstSel <= 4'd11);
  assign srcIxMem = (srcSel == 4'd12) || (srcSel == 4'd13);
  assign dstIxMem = (dstSel == 4'd12) || (dstSel == 4'd13);

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(decodeValid && prefixDrop)); // R6

  AST_DROP_COST: assert property (@(posedge clk) disable iff (!rstN)
    prefixDrop |-> (tStates == T_W'(PREFIX_NOP_T)) && (refreshInc == 2'd1)); // R6

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    prefixDrop |-> $past(byteValid) &&
      ($past(opByte) == 8'hDD || $past(opByte) == 8'hFD || $past(opByte) == 8'hED)); // R6

  AST_DECODE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid |-> $past(byteValid)); // R1

  AST_REFRESH_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid |-> refreshInc == ((page == 2'd0 && idxSel == 2'd0) ? 2'd1 : 2'd2)); // R1

  AST_PAGE_NO_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid && (page == 2'd1 || page == 2'd2) |-> idxSel == 2'd0); // R2

  AST_DISP_NEEDS_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid && needDisp |-> idxSel != 2'd0 && (srcIxMem || dstIxMem)); // R2

  AST_MEM_KEEPS_HL: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid && (srcIxMem || dstIxMem) |-> !srcHalf && !dstHalf); // R4

  AST_IXBIT_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid && page == 2'd3 |-> needDisp && srcIxMem && srcSel == dstSel); // R11

  AST_EXT_NOP_COST: assert property (@(posedge clk) disable iff (!rstN)
    decodeValid && kind == 3'd5 |-> tStates == T_W'(EXT_NOP_T) && page == 2'd2); // R8

  AST_QUIET_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    !decodeValid && !prefixDrop |-> tStates == '0 && refreshInc == 2'd0 &&
      srcSel == 4'd15 && dstSel == 4'd15); // R12

endmodule

bind prefix_decoder prefix_decoder_checker #(
  .PREFIX_NOP_T (PREFIX_NOP_T),
  .EXT_NOP_T    (EXT_NOP_T)
) u_chk (.*);

// File: tb/prefix_decoder_tb.sv
`timescale 1ns/1ps
module prefix_decoder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic       decodeValid, prefixDrop, needDisp;
  logic [1:0] page, idxSel, refreshInc;
  logic [3:0] srcSel, dstSel, tStates;
  logic [2:0] kind;

  always #10 clk = ~clk;

  prefix_decoder u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .opByte(opByte),
    .decodeValid(decodeValid), .prefixDrop(prefixDrop), .page(page),
    .idxSel(idxSel), .needDisp(needDisp), .srcSel(srcSel), .dstSel(dstSel),
    .kind(kind), .refreshInc(refreshInc), .tStates(tStates)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state: 0 idle, 1 index pending, 2 bit page, 3 ext page,
  // 4 awaiting displacement, 5 awaiting indexed bit opcode
  int mState = 0;
  int mIdx   = 0;
  int eValid, eDrop, ePage, eIdx, eNeed, eSrc, eDst, eKind, eRef, eT;
  string pendTag = "R12";

  task automatic clearExp();
    eValid = 0; eDrop = 0; ePage = 0; eIdx = 0; eNeed = 0;
    eSrc = 15; eDst = 15; eKind = 0; eRef = 0; eT = 0;
  endtask

  function automatic int remap(int c, int ix, int mem);
    if (ix == 0) return c;
    if (mem != 0) return (c == 6) ? 11 + ix : c;
    if (c == 4) return (ix == 1) ? 8 : 10;
    if (c == 5) return (ix == 1) ? 9 : 11;
    return c;
  endfunction

  task automatic complete(int pg, int ix, int b);
    int y, z, mem;
    y = (b >> 3) & 7;
    z = b & 7;
    eValid = 1; ePage = pg; eIdx = ix;
    eRef = (pg == 0 && ix == 0) ? 1 : 2;
    if (pg == 0) begin
      if (b >= 'h40 && b < 'h80 && b != 'h76) begin eDst = y; eSrc = z; end
      else if (b >= 'h80 && b < 'hC0) begin eDst = 7; eSrc = z; end
      else if (b < 'h40) begin
        if (z == 4 || z == 5) begin eSrc = y; eDst = y; end
        else if (z == 6) eDst = y;
      end
      if (b == 'hE9) eKind = 4;
      mem = (ix != 0 && (eSrc == 6 || eDst == 6)) ? 1 : 0;
      eNeed = mem;
      eSrc = remap(eSrc, ix, mem);
      eDst = remap(eDst, ix, mem);
    end else if (pg == 1) begin
      eSrc = z; eDst = z;
      if (b >= 'h30 && b <= 'h37) eKind = 1;
    end else if (pg == 2) begin
      if (b >= 'h40 && b < 'h80 && y != 6) begin
        if (z == 0) eDst = y;
        if (z == 1) eSrc = y;
      end
      if (b == 'h70) eKind = 2;
      else if (b == 'h71) eKind = 3;
      else if (b < 'h40 || b == 'h77 || b == 'h7F ||
               (b >= 'h80 && !((b >= 'hA0 && b <= 'hA3) || (b >= 'hA8 && b <= 'hAB) ||
                              (b >= 'hB0 && b <= 'hB3) || (b >= 'hB8 && b <= 'hBB)))) begin
        eKind = 5; eT = 8;
      end
    end else begin
      eSrc = 11 + ix; eDst = 11 + ix; eNeed = 1;
      if (b >= 'h30 && b <= 'h37) eKind = 1;
    end
  endtask

  task automatic modelStep(bit v, int b);
    bit isIdx;
    clearExp();
    if (!v) return;
    isIdx = (b == 'hDD || b == 'hFD);
    case (mState)
      0: if (b == 'hCB) mState = 2;
         else if (b == 'hED) mState = 3;
         else if (isIdx) begin mState = 1; mIdx = (b == 'hDD) ? 1 : 2; end
         else complete(0, 0, b);
      1: if (isIdx) begin eDrop = 1; eRef = 1; eT = 4; mIdx = (b == 'hDD) ? 1 : 2; end
         else if (b == 'hED) begin eDrop = 1; eRef = 1; eT = 4; mIdx = 0; mState = 3; end
         else if (b == 'hCB) mState = 4;
         else begin complete(0, mIdx, b); mState = 0; mIdx = 0; end
      2: begin complete(1, 0, b); mState = 0; end
      3: begin complete(2, 0, b); mState = 0; end
      4: mState = 5;
      default: begin complete(3, mIdx, b); mState = 0; mIdx = 0; end
    endcase
  endtask

  task automatic compare(string tag);
    checks++;
    if (decodeValid !== eValid[0] || prefixDrop !== eDrop[0] || page !== ePage[1:0] ||
        idxSel !== eIdx[1:0] || needDisp !== eNeed[0] || srcSel !== eSrc[3:0] ||
        dstSel !== eDst[3:0] || kind !== eKind[2:0] || refreshInc !== eRef[1:0] ||
        tStates !== eT[3:0]) begin
      fails++;
      $display("FAIL %s: actual v%0b d%0b pg%0d ix%0d nd%0b src%0d dst%0d k%0d r%0d t%0d expected v%0d d%0d pg%0d ix%0d nd%0d src%0d dst%0d k%0d r%0d t%0d",
               tag, decodeValid, prefixDrop, page, idxSel, needDisp, srcSel, dstSel,
               kind, refreshInc, tStates, eValid, eDrop, ePage, eIdx, eNeed, eSrc, eDst,
               eKind, eRef, eT);
    end
  endtask

  // compare the result of the previous byte, then present the next one
  task automatic feed(bit v, int b, string tag);
    @(negedge clk);
    compare(pendTag);
    byteValid = v;
    opByte    = b[7:0];
    modelStep(v, b);
    pendTag   = tag;
  endtask

  task automatic seq(string tag, int bytes[$]);
    foreach (bytes[i]) feed(1'b1, bytes[i], tag);
    feed(1'b0, 0, tag);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clearExp();
    repeat (3) @(negedge clk);
    compare("R12");                 // reset state during reset
    rstN = 1'b1;
    feed(1'b0, 0, "R12");
    feed(1'b0, 0, "R12");

    seq("R1",  '{'h00, 'h41, 'h80, 'h76, 'hCB, 'h00, 'hED, 'h44, 'h3E, 'h34});
    seq("R2",  '{'hDD, 'h7E, 'hFD, 'h86, 'hDD, 'h34, 'hFD, 'h36});
    seq("R3",  '{'hDD, 'h44, 'hFD, 'h65, 'hDD, 'h2C, 'hFD, 'h84});
    seq("R4",  '{'hDD, 'h66, 'hFD, 'h75, 'hDD, 'h6E});
    seq("R5",  '{'hDD, 'h41, 'hFD, 'h00, 'hDD, 'h87});
    seq("R6",  '{'hDD, 'hDD, 'hFD, 'h44, 'hFD, 'hED, 'h44, 'hFD, 'hDD, 'h7E});
    seq("R7",  '{'hCB, 'h35, 'hCB, 'h30, 'hCB, 'h37, 'hCB, 'h38, 'hFD, 'hCB, 'h05, 'h36});
    seq("R8",  '{'hED, 'h00, 'hED, 'h3F, 'hED, 'h77, 'hED, 'h7F, 'hED, 'hA0,
                 'hED, 'hBB, 'hED, 'hA4, 'hED, 'hFF, 'hED, 'hDD, 'h44});
    seq("R9",  '{'hED, 'h70, 'hED, 'h71, 'hED, 'h78, 'hED, 'h61});
    seq("R10", '{'hE9, 'hDD, 'hE9, 'hFD, 'hE9});
    seq("R11", '{'hDD, 'hCB, 'h12, 'h46, 'hFD, 'hCB, 'hCB, 'h06, 'hDD, 'hCB, 'hDD, 'h36});
    seq("R12", '{'hDD, 'h44, 'h44, 'hCB, 'hCB, 'h44});

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) feed(1'b0, 0, "R1");
      else if (r < 5) begin
        int p;
        p = $urandom_range(0, 3);
        feed(1'b1, (p == 0) ? 'hCB : (p == 1) ? 'hED : (p == 2) ? 'hDD : 'hFD, "R1");
      end else feed(1'b1, $urandom_range(0, 255), "R1");
    end
    feed(1'b0, 0, "R1");
    feed(1'b0, 0, "R1");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule